// File: doc/BRIEF.md
# Dual-Register Logic Macrocell

This block is one output cell of a small programmable logic device. It takes a bundle of product terms from an AND array, ORs them into sum terms, and stores the results in two flip-flops. Static configuration inputs choose the behaviour of each flip-flop: whether it loads or toggles, and whether it is clocked by the shared pin clock or by a product term of its own. Each flip-flop also has its own asynchronous reset term.

The first register drives the cell's pad and its own feedback line into the array. The second register is buried: it drives only a feedback line. A bypass setting routes that register's sum term straight onto the feedback line, so the cell can return combinational logic to the array without using a pin. The pad's output enable comes from a dedicated product term. The pad's input value is always fed back, whatever the enable state, so the pin can work in both directions.

Product terms arrive in three groups of four. The first group feeds the pad register, and the second group feeds the buried register. The third group is used only when the merge setting ORs all twelve terms into the pad register's sum.

Top module: `dual_reg_macrocell`

## Requirements
- R1: The pad register's sum is the OR of `pt_i[3:0]`, or of all of `pt_i[11:0]` when `cfg_merge_i` is 1. The buried register's sum is always the OR of `pt_i[7:4]`. When `cfg_merge_i` is 0, `pt_i[11:8]` has no effect.
- R2: In load mode (`cfg_t_mode_i[n]` = 0), register n takes its sum value on each active clock edge.
- R3: In toggle mode (`cfg_t_mode_i[n]` = 1), register n inverts on an active clock edge when its sum is 1, and holds when its sum is 0.
- R4: When `cfg_clk_sel_i[n]` = 0, register n is clocked by the rising edge of `pin_clk_i`. When it is 1, register n is clocked by the rising edge of `clk_pt_i[n]`, and `pin_clk_i` does not affect it.
- R5: While `rst_pt_i[n]` is 1, register n is cleared to 0 at once, and the other register is not affected. While `rst_ni` is 0, both registers are 0.
- R6: When `cfg_bypass_i` is 1, `reg_fb_o[1]` follows the buried register's sum combinationally. When it is 0, `reg_fb_o[1]` is the buried register's stored value.
- R7: `pad_o` and `reg_fb_o[0]` both show the pad register's stored value.
- R8: `pad_oe_o` follows `oe_pt_i`. `pin_fb_o` follows `pad_i` at all times, whatever the value of `oe_pt_i`.
- R9: Two registers on different clock sources update independently: an edge on one source never changes the register on the other source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pin_clk_i | input | 1 | Shared pin clock |
| rst_ni | input | 1 | Global asynchronous reset, active low |
| pt_i | input | 12 | Sum-term product terms, three groups of four |
| clk_pt_i | input | 2 | Clock product term for each register |
| rst_pt_i | input | 2 | Asynchronous reset term for each register, active high |
| oe_pt_i | input | 1 | Pad output-enable product term |
| pad_i | input | 1 | Value read from the pad |
| cfg_t_mode_i | input | 2 | Per register: 0 = load, 1 = toggle |
| cfg_clk_sel_i | input | 2 | Per register: 0 = pin clock, 1 = product-term clock |
| cfg_merge_i | input | 1 | ORs all three groups into the pad register's sum |
| cfg_bypass_i | input | 1 | Routes the buried register's sum to its feedback line |
| pad_o | output | 1 | Pad output data |
| pad_oe_o | output | 1 | Pad output enable |
| pin_fb_o | output | 1 | Pad input fed back to the array |
| reg_fb_o | output | 2 | Feedback from the pad register [0] and the buried register [1] |

## Verification
Random product-term patterns are applied under several random configurations, in phases. Setting bits only in the third group tells a merged sum apart from an unmerged one. Runs of all-ones and all-zeros sums tell toggle from load, and toggle from hold. Giving the two registers different clock sources, and pulsing only one of them, shows that each register follows its own clock and its own reset term. Varying `pad_i` while the enable is off shows that the input path does not depend on the enable.

// File: rtl/mcell_pkg.sv
package mcell_pkg;
  localparam int unsigned PT_PER_SUM = 4;
  localparam int unsigned NUM_SUMS   = 3;
  localparam int unsigned NUM_REGS   = 2;
  localparam int unsigned PT_W       = PT_PER_SUM * NUM_SUMS;

  typedef enum logic {
    MODE_LOAD   = 1'b0,
    MODE_TOGGLE = 1'b1
  } reg_mode_e;
endpackage

// File: rtl/mcell_sum_net.sv
module mcell_sum_net
  import mcell_pkg::*;
#(
  parameter int unsigned GRP_W  = PT_PER_SUM,
  parameter int unsigned GRP_N  = NUM_SUMS,
  localparam int unsigned IN_W  = GRP_W * GRP_N
) (
  input  logic [IN_W-1:0] pt_i,
  input  logic            merge_i,
  output logic            sum_a_o,
  output logic            sum_b_o
);
  logic [GRP_N-1:0] grp_or;

  for (genvar g = 0; g < GRP_N; g++) begin : g_grp
    assign grp_or[g] = |pt_i[g*GRP_W +: GRP_W];
  end

  // merged: every group feeds sum A, no extra gate level beyond the wide OR
  assign sum_a_o = merge_i ? (|grp_or) : grp_or[0];
  assign sum_b_o = grp_or[1];

  always_comb begin
    assert_merge_hit_R1: assert (!(merge_i && (|pt_i)) || sum_a_o);
    assert_unmerged_ignore_R1: assert (merge_i || (|pt_i[GRP_W-1:0]) || !sum_a_o);
  end
endmodule

// File: rtl/mcell_flop.sv
module mcell_flop
  import mcell_pkg::*;
(
  input  logic      pin_clk_i,
  input  logic      pt_clk_i,
  input  logic      clk_sel_i,
  input  logic      rst_ni,
  input  logic      rst_pt_i,
  input  reg_mode_e mode_i,
  input  logic      d_i,
  output logic      q_o
);
  logic clk_sel;
  logic rst_any;

  // config is static; mux only switches while both clocks are low
  assign clk_sel = clk_sel_i ? pt_clk_i : pin_clk_i;
  assign rst_any = ~rst_ni | rst_pt_i;

  always_ff @(posedge clk_sel or posedge rst_any) begin
    if (rst_any)                   q_o <= 1'b0;
    else if (mode_i == MODE_TOGGLE) q_o <= q_o ^ d_i;
    else                           q_o <= d_i;
  end

  assert_load_R2: assert property (@(posedge clk_sel) disable iff (rst_any)
    (mode_i == MODE_LOAD) |=> q_o == $past(d_i));

  assert_toggle_R3: assert property (@(posedge clk_sel) disable iff (rst_any)
    (mode_i == MODE_TOGGLE) |=> q_o == ($past(q_o) ^ $past(d_i)));

  assert_rst_clear_R5: assert property (@(posedge clk_sel) disable iff (!rst_ni)
    rst_pt_i |-> q_o == 1'b0);
endmodule

// File: rtl/dual_reg_macrocell.sv
module dual_reg_macrocell
  import mcell_pkg::*;
(
  input  logic                pin_clk_i,
  input  logic                rst_ni,
  input  logic [PT_W-1:0]     pt_i,
  input  logic [NUM_REGS-1:0] clk_pt_i,
  input  logic [NUM_REGS-1:0] rst_pt_i,
  input  logic                oe_pt_i,
  input  logic                pad_i,
  input  logic [NUM_REGS-1:0] cfg_t_mode_i,
  input  logic [NUM_REGS-1:0] cfg_clk_sel_i,
  input  logic                cfg_merge_i,
  input  logic                cfg_bypass_i,
  output logic                pad_o,
  output logic                pad_oe_o,
  output logic                pin_fb_o,
  output logic [NUM_REGS-1:0] reg_fb_o
);
  logic [NUM_REGS-1:0] sum_d;
  logic [NUM_REGS-1:0] q;

  mcell_sum_net #(
    .GRP_W (PT_PER_SUM),
    .GRP_N (NUM_SUMS)
  ) i_sum_net (
    .pt_i    (pt_i),
    .merge_i (cfg_merge_i),
    .sum_a_o (sum_d[0]),
    .sum_b_o (sum_d[1])
  );

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    mcell_flop i_flop (
      .pin_clk_i (pin_clk_i),
      .pt_clk_i  (clk_pt_i[r]),
      .clk_sel_i (cfg_clk_sel_i[r]),
      .rst_ni    (rst_ni),
      .rst_pt_i  (rst_pt_i[r]),
      .mode_i    (reg_mode_e'(cfg_t_mode_i[r])),
      .d_i       (sum_d[r]),
      .q_o       (q[r])
    );
  end

  assign pad_o       = q[0];
  assign reg_fb_o[0] = q[0];
  assign reg_fb_o[1] = cfg_bypass_i ? sum_d[1] : q[1];
  assign pad_oe_o    = oe_pt_i;
  assign pin_fb_o    = pad_i;

  assert_buried_reg_R6: assert property (@(posedge pin_clk_i)
    disable iff (!rst_ni || rst_pt_i[1])
    (!cfg_bypass_i && !cfg_clk_sel_i[1] && !cfg_t_mode_i[1])
      |=> reg_fb_o[1] == $past(sum_d[1]));

  assert_pad_match_R7: assert property (@(posedge pin_clk_i) disable iff (!rst_ni)
    pad_o == reg_fb_o[0]);
endmodule

// File: tb/test_dual_reg_macrocell.sv
module test_dual_reg_macrocell;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] pt;
  logic [1:0]  clk_pt, rst_pt, t_mode, clk_sel;
  logic        oe, pad_in, merge, bypass;
  logic        pad_out, pad_oe, pin_fb;
  logic [1:0]  reg_fb;

  // next configuration, applied only at a negedge with the product-term clocks low
  logic [1:0]  n_tmode, n_sel;
  logic        n_merge, n_bypass;
  logic [1:0]  m_q;
  int          checks = 0, fails = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  dual_reg_macrocell i_dual_reg_macrocell (
    .pin_clk_i(clk), .rst_ni(rst_n), .pt_i(pt), .clk_pt_i(clk_pt),
    .rst_pt_i(rst_pt), .oe_pt_i(oe), .pad_i(pad_in),
    .cfg_t_mode_i(t_mode), .cfg_clk_sel_i(clk_sel),
    .cfg_merge_i(merge), .cfg_bypass_i(bypass),
    .pad_o(pad_out), .pad_oe_o(pad_oe), .pin_fb_o(pin_fb), .reg_fb_o(reg_fb)
  );

  function automatic logic sum_of(int r, logic [11:0] p, logic mg);
    if (r == 0) return mg ? |p : |p[3:0];
    return |p[7:4];
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic upd(int r);
    if (t_mode[r]) m_q[r] = m_q[r] ^ sum_of(r, pt, merge);
    else           m_q[r] = sum_of(r, pt, merge);
  endtask

  task automatic step(logic [11:0] p, logic [1:0] ckp, logic [1:0] rp,
                      logic o, logic pd, string tag);
    logic [1:0] eff;
    @(negedge clk);
    clk_pt = 2'b00;
    t_mode = n_tmode; clk_sel = n_sel; merge = n_merge; bypass = n_bypass;
    pt = p; rst_pt = rp; oe = o; pad_in = pd;
    for (int r = 0; r < 2; r++) if (rp[r]) m_q[r] = 1'b0;
    #5;
    eff = ckp | rp;  // reset window always spans an edge of its own clock
    clk_pt = eff;
    for (int r = 0; r < 2; r++) if (clk_sel[r] && eff[r] && !rp[r]) upd(r);
    @(posedge clk);
    for (int r = 0; r < 2; r++) if (!clk_sel[r] && !rp[r]) upd(r);
    #2;
    chk({tag, " R7 pad"}, pad_out, m_q[0]);
    chk({tag, t_mode[0] ? " R3 fb0" : " R2 fb0"}, reg_fb[0], m_q[0]);
    chk({tag, bypass ? " R6 fb1" : (t_mode[1] ? " R3 fb1" : " R2 fb1")},
        reg_fb[1], bypass ? sum_of(1, pt, merge) : m_q[1]);
    chk({tag, " R8 oe"}, pad_oe, o);
    chk({tag, " R8 pin"}, pin_fb, pd);
  endtask

  task automatic cfg(logic [1:0] tm, logic [1:0] sl, logic mg, logic bp);
    n_tmode = tm; n_sel = sl; n_merge = mg; n_bypass = bp;
  endtask

  initial begin
    logic [31:0] rv;
    rv = $urandom(32'd2024);
    m_q = 2'b00;
    rst_n = 1'b0; pt = '0; clk_pt = '0; rst_pt = '0; oe = 0; pad_in = 0;
    t_mode = '0; clk_sel = '0; merge = 0; bypass = 0;
    cfg(2'b00, 2'b00, 0, 0);
    pt = 12'hFFF;
    repeat (3) @(posedge clk);
    #2;
    chk("R5 global reset pad", pad_out, 1'b0);
    chk("R5 global reset fb", reg_fb[1], 1'b0);
    @(negedge clk); rst_n = 1'b1; pt = '0;

    // R1: third group only reaches sum A when merged
    step(12'h200, 2'b00, 2'b00, 0, 0, "R1 unmerged");
    cfg(2'b00, 2'b00, 1, 0);
    step(12'h200, 2'b00, 2'b00, 0, 0, "R1 merged");
    step(12'h040, 2'b00, 2'b00, 0, 0, "R1 groupb");

    // R3: toggle and hold
    cfg(2'b11, 2'b00, 0, 0);
    repeat (3) step(12'h0FF, 2'b00, 2'b00, 1, 1, "R3 toggle");
    repeat (2) step(12'h000, 2'b00, 2'b00, 1, 0, "R3 hold");

    // R5: reset only register 0, register 1 keeps toggling
    step(12'h0FF, 2'b00, 2'b01, 0, 1, "R5 rst0");
    step(12'h0FF, 2'b00, 2'b10, 0, 1, "R5 rst1");

    // R4 R9: register 1 on product-term clock, not pulsed, while pin clock runs
    cfg(2'b11, 2'b10, 0, 0);
    repeat (3) step(12'h0FF, 2'b00, 2'b00, 0, 1, "R4 R9 pt idle");
    step(12'h0FF, 2'b10, 2'b00, 0, 1, "R4 pt edge");
    cfg(2'b11, 2'b01, 0, 0);
    repeat (2) step(12'h0FF, 2'b10, 2'b00, 0, 0, "R9 split");
    step(12'h0FF, 2'b01, 2'b00, 0, 0, "R4 R9 pt0");

    // R6: bypass exposes sum B combinationally
    cfg(2'b00, 2'b00, 0, 1);
    step(12'h010, 2'b00, 2'b00, 0, 1, "R6 on");
    step(12'h000, 2'b00, 2'b00, 0, 1, "R6 on low");

    // random phases
    for (int ph = 0; ph < 8; ph++) begin
      rv = $urandom;
      cfg(rv[1:0], rv[3:2], rv[4], rv[5]);
      for (int i = 0; i < 150; i++) begin
        logic [31:0] s;
        s = $urandom;
        step(s[11:0], s[13:12], (s[20:16] == 5'd0) ? s[22:21] : 2'b00,
             s[23], s[24], "rand");
      end
    end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule